// File: doc/BRIEF.md
# Board interrupt expander controller

This block gathers sixteen external interrupt request lines into one level interrupt for a host processor. Each request line, after a two-stage synchronizer, sets a sticky bit in a status register. Software acknowledges a line by writing a one to that bit. An enable mask decides which latched bits reach the summary output. The mask has no plain write port. One address sets enable bits for every one written, and a second address clears them. Reading either address returns the mask. A further address returns the present synchronized level of the request lines.

The host uses a simple synchronous register bus with one address, write enable, write data, read enable and registered read data. A typical start-up writes all ones to the mask-clear address and then all ones to the status address. After that, software enables the lines it serves. Its handler reads the mask and the status, serves each bit set in both, and writes that bit back to the status address.

Top module: `irqx_top`

## Requirements
- R1: After a synchronous reset, the status register and the enable mask are all zeros, `irqOut` is 0 and `busRdata` is 0.
- R2: A request input held high for three clock cycles sets its status bit (bit n belongs to line n). The bit stays set after the input returns low.
- R3: Writing to offset 0x16 clears every status bit written as 1 and leaves bits written as 0 unchanged. A read of 0x16 returns the status register.
- R4: If a line's synchronized request is high in the cycle that software writes 1 to its status bit, the bit stays set.
- R5: A read of offset 0x18 returns the synchronized live level of the request inputs. A write to 0x18 changes nothing.
- R6: Writing to offset 0x1A sets every enable bit written as 1 and leaves the other bits alone. A read of 0x1A returns the whole enable mask.
- R7: Writing to offset 0x1C clears every enable bit written as 1 and leaves the other bits alone. A read of 0x1C returns the enable mask and changes no state.
- R8: A masked line still latches its status bit.
- R9: `irqOut` is high exactly while some bit is set in both the status register and the enable mask.
- R10: A read of any other offset returns zero, and a write to any other offset changes no state.
- R11: Read data appears on `busRdata` in the cycle after the cycle with `busRe` high. It is zero in a cycle that follows no read.
- R12: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every line disabled, every status bit cleared and `irqOut` low, once the request inputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W (8) | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | NUM_LINES (16) | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | NUM_LINES (16) | Registered read data |
| irqReq | input | NUM_LINES (16) | External request lines, active high |
| irqOut | output | 1 | Summary interrupt, active-high level |

## Verification
The bench builds the block with its default parameters: sixteen lines, an 8-bit offset and a two-stage synchronizer. With these values every offset, including an unmapped one, can be reached from the vector table. The three-cycle request-to-status latency lets the bench hold a request high across a status write, which reaches the case where the set wins over the clear. With all sixteen lines, the all-ones start-up sequence covers the full register width.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_LIVE   = 2'd2,
    RD_MASK   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrMaskSet;
    logic   wrMaskClr;
    logic   rdEn;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stageQ[s] <= '0;
        else     stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stageQ[s] <= '0;
        else     stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [7:0]  OFS_STATUS   = 8'h16,
  parameter logic [7:0]  OFS_LIVE     = 8'h18,
  parameter logic [7:0]  OFS_MASK_SET = 8'h1A,
  parameter logic [7:0]  OFS_MASK_CLR = 8'h1C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output busStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_LIVE   = ADDR_W'(OFS_LIVE);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_MASK_CLR);

  logic hitStatus, hitLive, hitSet, hitClr;

  always_comb begin
    hitStatus = (busAddr == A_STATUS);
    hitLive   = (busAddr == A_LIVE);
    hitSet    = (busAddr == A_SET);
    hitClr    = (busAddr == A_CLR);

    strb           = '0;
    strb.wrStatus  = busWe & hitStatus;
    strb.wrMaskSet = busWe & hitSet;
    strb.wrMaskClr = busWe & hitClr;
    strb.rdEn      = busRe;
    if (hitStatus)             strb.rdSel = RD_STATUS;
    else if (hitLive)          strb.rdSel = RD_LIVE;
    else if (hitSet || hitClr) strb.rdSel = RD_MASK;
    else                       strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqx_datapath.sv
module irqx_datapath
  import irqx_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  busStrobe_t           strb,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic [NUM_LINES-1:0] busRdata,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] syncReq;
  logic [NUM_LINES-1:0] statusQ, maskQ, rdataQ;
  logic [NUM_LINES-1:0] ackVec, rdMux;

  irqx_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (irqReq),
    .syncOut (syncReq)
  );

  assign ackVec = strb.wrStatus ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= (statusQ & ~ackVec) | syncReq;
  end

  always_ff @(posedge clk) begin
    if (rst)                 maskQ <= '0;
    else if (strb.wrMaskSet) maskQ <= maskQ | busWdata;
    else if (strb.wrMaskClr) maskQ <= maskQ & ~busWdata;
  end

  always_comb begin
    case (strb.rdSel)
      RD_STATUS: rdMux = statusQ;
      RD_LIVE:   rdMux = syncReq;
      RD_MASK:   rdMux = maskQ;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdMux;
    else                rdataQ <= '0;
  end

  assign busRdata = rdataQ;
  assign irqOut   = |(statusQ & maskQ);

  // R3: acknowledged bits without a concurrent request are gone next cycle
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    strb.wrStatus |=> ((statusQ & $past(busWdata & ~syncReq)) == '0));

  // R4: a synchronized request always leaves its bit set
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (syncReq != '0) |=> ((statusQ & $past(syncReq)) == $past(syncReq)));

  // R2: without an acknowledge no status bit falls
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.wrStatus |=> (($past(statusQ) & ~statusQ) == '0));

  // R6: set alias raises every written one
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
    strb.wrMaskSet |=> ((maskQ & $past(busWdata)) == $past(busWdata)));

  // R7: clear alias drops every written one
  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
    strb.wrMaskClr |=> ((maskQ & $past(busWdata)) == '0));

  // R7: the mask moves only under a mask write
  assert_mask_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrMaskSet || strb.wrMaskClr) |=> $stable(maskQ));

  // R11: no read strobe means zero read data next cycle
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> (busRdata == '0));

endmodule

// File: rtl/irqx_top.sv
module irqx_top
  import irqx_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [NUM_LINES-1:0] busWdata,
  input  logic                 busRe,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic                 irqOut
);

  busStrobe_t strb;

  irqx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strb    (strb)
  );

  irqx_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .busWdata (busWdata),
    .irqReq   (irqReq),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  // R1: outputs are quiet in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (busRdata == '0 && irqOut == 1'b0));

endmodule

// File: tb/sim_irqx_top.sv
module sim_irqx_top;

  localparam int NL = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [NL-1:0] busWdata = '0;
  logic          busRe = 1'b0;
  logic [NL-1:0] busRdata;
  logic [NL-1:0] irqReq = '0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irqx_top u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .irqReq(irqReq), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read, 2 request level
    logic [7:0]  tag;   // requirement number
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    '{2'd2, 8'd2,  8'h00, 16'h0005, 16'h0000, 1'b0}, // R2 raise lines 0,2
    '{2'd1, 8'd2,  8'h16, 16'h0000, 16'h0005, 1'b0}, // R2 latched
    '{2'd1, 8'd5,  8'h18, 16'h0000, 16'h0005, 1'b0}, // R5 live
    '{2'd1, 8'd8,  8'h1A, 16'h0000, 16'h0000, 1'b0}, // R8 masked yet latched
    '{2'd2, 8'd2,  8'h00, 16'h0000, 16'h0000, 1'b0}, // R2 drop lines
    '{2'd1, 8'd2,  8'h16, 16'h0000, 16'h0005, 1'b0}, // R2 sticky
    '{2'd1, 8'd5,  8'h18, 16'h0000, 16'h0000, 1'b0}, // R5 live low
    '{2'd0, 8'd9,  8'h1A, 16'h0004, 16'h0000, 1'b1}, // R9 enable line 2
    '{2'd1, 8'd6,  8'h1A, 16'h0000, 16'h0004, 1'b1}, // R6 mask readback
    '{2'd0, 8'd3,  8'h16, 16'h0004, 16'h0000, 1'b0}, // R3 ack line 2
    '{2'd1, 8'd3,  8'h16, 16'h0000, 16'h0001, 1'b0}, // R3 only bit 0 left
    '{2'd0, 8'd6,  8'h1A, 16'h0001, 16'h0000, 1'b1}, // R6 enable line 0
    '{2'd1, 8'd7,  8'h1C, 16'h0000, 16'h0005, 1'b1}, // R7 clear alias reads mask
    '{2'd0, 8'd7,  8'h1C, 16'h0001, 16'h0000, 1'b0}, // R7 disable line 0
    '{2'd1, 8'd7,  8'h1A, 16'h0000, 16'h0004, 1'b0}, // R7 line 2 kept
    '{2'd0, 8'd5,  8'h18, 16'hFFFF, 16'h0000, 1'b0}, // R5 write ignored
    '{2'd1, 8'd5,  8'h18, 16'h0000, 16'h0000, 1'b0}, // R5
    '{2'd1, 8'd10, 8'h30, 16'h0000, 16'h0000, 1'b0}, // R10 unmapped read
    '{2'd0, 8'd10, 8'h30, 16'hFFFF, 16'h0000, 1'b0}, // R10 unmapped write
    '{2'd1, 8'd10, 8'h1A, 16'h0000, 16'h0004, 1'b0}, // R10 mask untouched
    '{2'd1, 8'd10, 8'h16, 16'h0000, 16'h0001, 1'b0}, // R10 status untouched
    '{2'd0, 8'd3,  8'h16, 16'h0000, 16'h0000, 1'b0}, // R3 zero write
    '{2'd1, 8'd3,  8'h16, 16'h0000, 16'h0001, 1'b0}  // R3 bit kept
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic setReq(input logic [15:0] v);
    @(negedge clk);
    irqReq = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=expired expected=done");
    finish();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", busRdata, 16'h0000);
    check("R1 irqOut", {15'd0, irqOut}, 16'h0000);
    doRead(8'h16, rd); check("R1 status", rd, 16'h0000);
    doRead(8'h1A, rd); check("R1 mask", rd, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        2'd0: doWrite(VEC[i].addr, VEC[i].data);
        2'd1: begin
          doRead(VEC[i].addr, rd);
          check($sformatf("R%0d vec%0d rdata", VEC[i].tag, i), rd, VEC[i].exp);
        end
        default: setReq(VEC[i].data);
      endcase
      check($sformatf("R%0d vec%0d irqOut", VEC[i].tag, i), {15'd0, irqOut}, {15'd0, VEC[i].expIrq});
    end

    // R11 latency: not yet valid in the strobe cycle, valid after, zero again later
    @(negedge clk);
    busAddr = 8'h1A; busRe = 1'b1;
    #1 check("R11 before edge", busRdata, 16'h0000);
    @(negedge clk);
    busRe = 1'b0;
    check("R11 valid", busRdata, 16'h0004);
    @(negedge clk);
    check("R11 idle zero", busRdata, 16'h0000);

    // R4 set wins over acknowledge while the line stays high
    setReq(16'h0008);
    doWrite(8'h16, 16'h0008);
    doRead(8'h16, rd); check("R4 set wins", rd & 16'h0008, 16'h0008);
    setReq(16'h0000);
    doWrite(8'h16, 16'h0008);
    doRead(8'h16, rd); check("R4 cleared after drop", rd & 16'h0008, 16'h0000);

    // R12 start-up sequence from a busy state
    doWrite(8'h1A, 16'hFFFF);
    setReq(16'hFFFF);
    setReq(16'h0000);
    check("R12 busy irqOut", {15'd0, irqOut}, 16'h0001);
    doWrite(8'h1C, 16'hFFFF);
    doWrite(8'h16, 16'hFFFF);
    doRead(8'h16, rd); check("R12 status", rd, 16'h0000);
    doRead(8'h1A, rd); check("R12 mask", rd, 16'h0000);
    check("R12 irqOut", {15'd0, irqOut}, 16'h0000);

    finish();
  end

endmodule